// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is the status and control register bank of a board-level system controller. It sits on a simple 32-bit register bus with a select, a write enable, an address inside a 4 KB window, write data and registered read data. Software reads a fixed identification word, drives a bank of LED outputs, and keeps two configuration words. It also keeps two flag registers, one volatile and one non-volatile. Each flag register has one address that ORs data in and a second address that clears the bits set in the data, and both are read back at the set address.

A reset control register guards the board reset. It accepts a write only while a lock register holds the unlock key 0xA05F. An accepted write with bit 8 set produces a one-cycle board-reset request. A handful of addresses return fixed constants, and every other address in the window reads as zero and ignores writes. Two reset inputs are provided. The system reset clears all volatile state. The power-on reset is the only thing that clears the non-volatile flags.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, reading byte offset 0x000 returns the parameter ID_VALUE. Writes to 0x000 never change that value.
- R2: Byte offset 0x008 is a read/write LED word. The `leds` port shows its low NUM_LEDS bits, starting on the cycle after the write.
- R3: A write to offset 0x020 stores 0x0000A05F when the write data equals 0x0000A05F exactly. Any other data is stored as its low 16 bits with bit 15 cleared. A read returns the stored 16 bits zero-extended.
- R4: A write to offset 0x040 (reset control) takes effect only if the lock register held 0xA05F before that write cycle. Otherwise the write is dropped. A read returns the current value.
- R5: An accepted reset-control write with data bit 8 set drives `boardResetReq` high for exactly one cycle, the cycle after the write. No other write raises it.
- R6: The volatile flags are read at 0x030. A write to 0x030 ORs the data into the flags, and a write to 0x034 clears every flag bit that is 1 in the data.
- R7: The non-volatile flags are read at 0x038. A write to 0x038 ORs the data in, and a write to 0x03C clears the bits that are 1 in the data. Only `porN` clears them; `rstN` leaves them unchanged.
- R8: Offsets 0x028 and 0x02C are plain 32-bit read/write configuration words.
- R9: Offsets 0x044, 0x050, 0x084 and 0x088 read 0x00000001, 0x00001000, 0x02000000 and 0xFF000000. Writes to them have no effect.
- R10: Every other offset in the window reads zero. This includes 0x034 and 0x03C. Writes to those offsets change no register and no output.
- R11: `rdata` is loaded on the clock edge that samples `sel`=1 and `wrEn`=0. It holds its value on every other cycle. Address bits [1:0] are ignored.
- R12: While `rstN` is low, `rdata`, the LED word, the lock register, reset control, both configuration words and the volatile flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset (volatile state) |
| porN | input | 1 | Active-low power-on reset (non-volatile flags) |
| sel | input | 1 | Bus select for the current cycle |
| wrEn | input | 1 | 1 = write, 0 = read, when `sel` is high |
| addr | input | ADDR_W (12) | Byte address within the window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| leds | output | NUM_LEDS (8) | LED drive, the low bits of the LED word |
| boardResetReq | output | 1 | One-cycle board reset request |

## Verification
The bench targets the lock boundary. It writes key-like values with extra upper bits, which a design comparing only 16 bits would accept as the key. It relocks and then writes reset control, which a design checking the lock after the write, or not at all, would accept. It checks that the reset pulse lasts exactly one cycle and appears only when bit 8 is set. It mixes set and clear writes to both flag registers. A design that swapped OR and AND-NOT, or wired the clear address to the read path, would return different words. A system reset in the middle of the run must leave the non-volatile flags intact and clear everything else. Constant and unmapped addresses are written and then read back to show the writes had no effect.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

  // Byte offsets inside the 4 KB window; software depends on these values.
  localparam logic [11:0] OFF_ID      = 12'h000;
  localparam logic [11:0] OFF_LED     = 12'h008;
  localparam logic [11:0] OFF_LOCK    = 12'h020;
  localparam logic [11:0] OFF_CFG1    = 12'h028;
  localparam logic [11:0] OFF_CFG2    = 12'h02C;
  localparam logic [11:0] OFF_FSET    = 12'h030;
  localparam logic [11:0] OFF_FCLR    = 12'h034;
  localparam logic [11:0] OFF_NVSET   = 12'h038;
  localparam logic [11:0] OFF_NVCLR   = 12'h03C;
  localparam logic [11:0] OFF_RSTCTL  = 12'h040;
  localparam logic [11:0] OFF_PCI     = 12'h044;
  localparam logic [11:0] OFF_LCD     = 12'h050;
  localparam logic [11:0] OFF_CORE0   = 12'h084;
  localparam logic [11:0] OFF_CORE1   = 12'h088;

  localparam int          LOCK_W      = 16;
  localparam logic [15:0] LOCK_KEY    = 16'hA05F;
  localparam int          RST_REQ_BIT = 8;

  localparam logic [31:0] K_PCI   = 32'h0000_0001;
  localparam logic [31:0] K_LCD   = 32'h0000_1000;
  localparam logic [31:0] K_CORE0 = 32'h0200_0000;
  localparam logic [31:0] K_CORE1 = 32'hFF00_0000;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ID, RS_LED, RS_LOCK, RS_CFG1, RS_CFG2, RS_FLAG,
    RS_NVFLAG, RS_RSTCTL, RS_PCI, RS_LCD, RS_CORE0, RS_CORE1
  } rdSrcE;

  typedef struct packed {
    logic  wrLed;
    logic  wrLock;
    logic  wrRstCtl;
    logic  wrCfg1;
    logic  wrCfg2;
    logic  flagSet;
    logic  flagClr;
    logic  nvSet;
    logic  nvClr;
    logic  rdEn;
    rdSrcE rdSrc;
  } strobeT;

endpackage

// File: rtl/sysctl_ctrl.sv
`timescale 1ns/1ps
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strobe
);

  logic [ADDR_W-1:0] wordAddr;
  logic              wrCyc;
  logic              rdCyc;

  assign wordAddr = {addr[ADDR_W-1:2], 2'b00};
  assign wrCyc    = sel & wrEn;
  assign rdCyc    = sel & ~wrEn;

  always_comb begin
    strobe       = '0;
    strobe.rdEn  = rdCyc;
    strobe.rdSrc = RS_ZERO;
    case (wordAddr)
      ADDR_W'(OFF_ID):     strobe.rdSrc = RS_ID;
      ADDR_W'(OFF_LED): begin
        strobe.rdSrc = RS_LED;
        strobe.wrLed = wrCyc;
      end
      ADDR_W'(OFF_LOCK): begin
        strobe.rdSrc  = RS_LOCK;
        strobe.wrLock = wrCyc;
      end
      ADDR_W'(OFF_CFG1): begin
        strobe.rdSrc  = RS_CFG1;
        strobe.wrCfg1 = wrCyc;
      end
      ADDR_W'(OFF_CFG2): begin
        strobe.rdSrc  = RS_CFG2;
        strobe.wrCfg2 = wrCyc;
      end
      ADDR_W'(OFF_FSET): begin
        strobe.rdSrc   = RS_FLAG;
        strobe.flagSet = wrCyc;
      end
      ADDR_W'(OFF_FCLR):   strobe.flagClr = wrCyc;
      ADDR_W'(OFF_NVSET): begin
        strobe.rdSrc = RS_NVFLAG;
        strobe.nvSet = wrCyc;
      end
      ADDR_W'(OFF_NVCLR):  strobe.nvClr = wrCyc;
      ADDR_W'(OFF_RSTCTL): begin
        strobe.rdSrc    = RS_RSTCTL;
        strobe.wrRstCtl = wrCyc;
      end
      ADDR_W'(OFF_PCI):    strobe.rdSrc = RS_PCI;
      ADDR_W'(OFF_LCD):    strobe.rdSrc = RS_LCD;
      ADDR_W'(OFF_CORE0):  strobe.rdSrc = RS_CORE0;
      ADDR_W'(OFF_CORE1):  strobe.rdSrc = RS_CORE1;
      default:             strobe.rdSrc = RS_ZERO;
    endcase
  end

  // At most one register may take a given bus write.
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrLed, strobe.wrLock, strobe.wrRstCtl, strobe.wrCfg1, strobe.wrCfg2,
              strobe.flagSet, strobe.flagClr, strobe.nvSet, strobe.nvClr})); // R10

  // Nothing is written while the bus is idle.
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> !(strobe.wrLed || strobe.wrLock || strobe.wrRstCtl || strobe.wrCfg1 ||
               strobe.wrCfg2 || strobe.flagSet || strobe.flagClr || strobe.nvSet ||
               strobe.nvClr || strobe.rdEn)); // R11

endmodule

// File: rtl/sysctl_flagbank.sv
`timescale 1ns/1ps
module sysctl_flagbank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              setEn,
  input  logic              clrEn,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flags
);

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)      flags <= '0;
    else if (setEn) flags <= flags | wdata;
    else if (clrEn) flags <= flags & ~wdata;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!clrN)
    setEn |=> ((flags & $past(wdata)) == $past(wdata))); // R6

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!clrN)
    clrEn |=> ((flags & $past(wdata)) == '0)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!clrN)
    (!setEn && !clrEn) |=> $stable(flags)); // R7

endmodule

// File: rtl/sysctl_dp.sv
`timescale 1ns/1ps
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          NUM_LEDS = 8,
  parameter logic [31:0] ID_VALUE = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                porN,
  input  strobeT              strobe,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_LEDS-1:0] leds,
  output logic                boardResetReq
);

  logic [DATA_W-1:0] ledReg;
  logic [LOCK_W-1:0] lockReg;
  logic [LOCK_W-1:0] lockNext;
  logic [DATA_W-1:0] cfg1Reg;
  logic [DATA_W-1:0] cfg2Reg;
  logic [DATA_W-1:0] rstCtlReg;
  logic [DATA_W-1:0] flagVal;
  logic [DATA_W-1:0] nvFlagVal;
  logic [DATA_W-1:0] readMux;
  logic              unlocked;
  logic              rstWrOk;

  // Lock value before this cycle's write decides acceptance.
  assign unlocked = (lockReg == LOCK_KEY);
  assign rstWrOk  = strobe.wrRstCtl & unlocked;
  assign lockNext = (wdata == DATA_W'(LOCK_KEY)) ? LOCK_KEY
                                                 : {1'b0, wdata[LOCK_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg        <= '0;
      lockReg       <= '0;
      cfg1Reg       <= '0;
      cfg2Reg       <= '0;
      rstCtlReg     <= '0;
      boardResetReq <= 1'b0;
    end else begin
      if (strobe.wrLed)  ledReg  <= wdata;
      if (strobe.wrLock) lockReg <= lockNext;
      if (strobe.wrCfg1) cfg1Reg <= wdata;
      if (strobe.wrCfg2) cfg2Reg <= wdata;
      if (rstWrOk)       rstCtlReg <= wdata;
      boardResetReq <= rstWrOk & wdata[RST_REQ_BIT];
    end
  end

  sysctl_flagbank #(.DATA_W(DATA_W)) u_volFlags (
    .clk   (clk),
    .clrN  (rstN),
    .setEn (strobe.flagSet),
    .clrEn (strobe.flagClr),
    .wdata (wdata),
    .flags (flagVal)
  );

  sysctl_flagbank #(.DATA_W(DATA_W)) u_nvFlags (
    .clk   (clk),
    .clrN  (porN),
    .setEn (strobe.nvSet),
    .clrEn (strobe.nvClr),
    .wdata (wdata),
    .flags (nvFlagVal)
  );

  always_comb begin
    case (strobe.rdSrc)
      RS_ID:     readMux = DATA_W'(ID_VALUE);
      RS_LED:    readMux = ledReg;
      RS_LOCK:   readMux = DATA_W'(lockReg);
      RS_CFG1:   readMux = cfg1Reg;
      RS_CFG2:   readMux = cfg2Reg;
      RS_FLAG:   readMux = flagVal;
      RS_NVFLAG: readMux = nvFlagVal;
      RS_RSTCTL: readMux = rstCtlReg;
      RS_PCI:    readMux = DATA_W'(K_PCI);
      RS_LCD:    readMux = DATA_W'(K_LCD);
      RS_CORE0:  readMux = DATA_W'(K_CORE0);
      RS_CORE1:  readMux = DATA_W'(K_CORE1);
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (strobe.rdEn) rdata <= readMux;
  end

  generate
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      assign leds[i] = ledReg[i];
    end
  endgenerate

  AST_LOCK_TOP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    lockReg[LOCK_W-1] |-> (lockReg == LOCK_KEY)); // R3

  AST_LOCKED_RST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrRstCtl && !unlocked) |=> $stable(rstCtlReg)); // R4

  AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    boardResetReq |=> !boardResetReq); // R5

  AST_LOCKED_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrRstCtl && !unlocked) |=> !boardResetReq); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdata)); // R11

endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          NUM_LEDS = 8,
  parameter logic [31:0] ID_VALUE = 32'h1780_0500
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                porN,
  input  logic                sel,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_LEDS-1:0] leds,
  output logic                boardResetReq
);

  strobeT strobe;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  sysctl_dp #(
    .DATA_W   (DATA_W),
    .NUM_LEDS (NUM_LEDS),
    .ID_VALUE (ID_VALUE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .porN          (porN),
    .strobe        (strobe),
    .wdata         (wdata),
    .rdata         (rdata),
    .leds          (leds),
    .boardResetReq (boardResetReq)
  );

endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;

  localparam logic [31:0] ID = 32'h1780_0500;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN, porN, sel, wrEn;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  leds;
  logic        boardResetReq;

  int checks = 0;
  int errors = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        readPending = 1'b0;

  always #4 clk = ~clk;

  sysctl_regbank #(.ID_VALUE(ID)) u_sysctl_regbank (
    .clk(clk), .rstN(rstN), .porN(porN), .sel(sel), .wrEn(wrEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .leds(leds),
    .boardResetReq(boardResetReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0;
  endtask

  // Driver: push the expected word, then issue the read.
  task automatic busRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    sel = 1'b1; wrEn = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: rdata is valid one edge after the read select.
  always @(posedge clk) readPending <= rstN && sel && !wrEn;

  always @(negedge clk) begin
    if (readPending) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read actual=%08h expected=none", rdata);
      end else begin
        chk(tagQ.pop_front(), rdata, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; porN = 1'b0; sel = 1'b0; wrEn = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    @(negedge clk);

    // R12 / R1 reset state
    chk("R12 leds after reset", 32'(leds), 32'h0);
    chk("R12 rdata after reset", rdata, 32'h0);
    busRead(12'h000, ID, "R1 id");
    busRead(12'h008, 32'h0, "R12 led word");
    busRead(12'h020, 32'h0, "R12 lock");
    busRead(12'h040, 32'h0, "R12 rstctl");
    busRead(12'h030, 32'h0, "R12 flags");
    busRead(12'h038, 32'h0, "R7 nvflags por");
    busWrite(12'h000, 32'hFFFF_FFFF);
    busRead(12'h000, ID, "R1 id write ignored");
    busRead(12'h003, ID, "R11 low addr bits ignored");

    // R2 LEDs
    busWrite(12'h008, 32'h1234_56A5);
    chk("R2 leds port", 32'(leds), 32'h0000_00A5);
    busRead(12'h008, 32'h1234_56A5, "R2 led word");

    // R3 lock encoding
    busWrite(12'h020, 32'h0000_FFFF);
    busRead(12'h020, 32'h0000_7FFF, "R3 bit15 cleared");
    busWrite(12'h020, 32'h0001_A05F);
    busRead(12'h020, 32'h0000_205F, "R3 near key");

    // R4/R5 locked write dropped
    busWrite(12'h040, 32'h0000_01FF);
    chk("R5 no pulse when locked", 32'(boardResetReq), 32'h0);
    busRead(12'h040, 32'h0, "R4 locked drop");

    // unlock
    busWrite(12'h020, 32'h0000_A05F);
    busRead(12'h020, 32'h0000_A05F, "R3 key stored");
    busWrite(12'h040, 32'h0000_00C3);
    chk("R5 no pulse bit8 clear", 32'(boardResetReq), 32'h0);
    busRead(12'h040, 32'h0000_00C3, "R4 unlocked write");
    busWrite(12'h040, 32'h0000_0155);
    chk("R5 pulse high", 32'(boardResetReq), 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", 32'(boardResetReq), 32'h0);
    busRead(12'h040, 32'h0000_0155, "R4 value kept");

    // relock: next write dropped
    busWrite(12'h020, 32'h0);
    busWrite(12'h040, 32'h0000_0177);
    chk("R5 no pulse after relock", 32'(boardResetReq), 32'h0);
    busRead(12'h040, 32'h0000_0155, "R4 relocked drop");

    // R6 flags
    busWrite(12'h030, 32'hF0F0_0001);
    busWrite(12'h030, 32'h0000_0300);
    busRead(12'h030, 32'hF0F0_0301, "R6 set or");
    busWrite(12'h034, 32'h3000_0101);
    busRead(12'h030, 32'hC0F0_0200, "R6 clear");

    // R7 nv flags
    busWrite(12'h038, 32'h8000_000F);
    busWrite(12'h03C, 32'h0000_0005);
    busRead(12'h038, 32'h8000_000A, "R7 set clear");

    // R8 config words
    busWrite(12'h028, 32'hDEAD_BEEF);
    busWrite(12'h02C, 32'h0BAD_F00D);
    busRead(12'h028, 32'hDEAD_BEEF, "R8 cfg1");
    busRead(12'h02C, 32'h0BAD_F00D, "R8 cfg2");

    // R9 constants
    busWrite(12'h044, 32'h0);
    busWrite(12'h050, 32'h0);
    busWrite(12'h084, 32'h0);
    busWrite(12'h088, 32'h0);
    busRead(12'h044, 32'h0000_0001, "R9 k44");
    busRead(12'h050, 32'h0000_1000, "R9 k50");
    busRead(12'h084, 32'h0200_0000, "R9 k84");
    busRead(12'h088, 32'hFF00_0000, "R9 k88");

    // R10 unmapped
    busWrite(12'h004, 32'hFFFF_FFFF);
    busWrite(12'h00C, 32'hFFFF_FFFF);
    busWrite(12'h024, 32'hFFFF_FFFF);
    busWrite(12'hFFC, 32'hFFFF_FFFF);
    chk("R10 leds untouched", 32'(leds), 32'h0000_00A5);
    busRead(12'h004, 32'h0, "R10 r04");
    busRead(12'h00C, 32'h0, "R10 r0c");
    busRead(12'hFFC, 32'h0, "R10 rffc");
    busRead(12'h034, 32'h0, "R10 clr addr reads zero");
    busRead(12'h03C, 32'h0, "R10 nvclr addr reads zero");
    busRead(12'h008, 32'h1234_56A5, "R10 led word untouched");
    busRead(12'h028, 32'hDEAD_BEEF, "R10 cfg1 untouched");
    drain();

    // R11 hold
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", rdata, 32'hDEAD_BEEF);

    // R12 system reset keeps nv flags
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 leds cleared", 32'(leds), 32'h0);
    chk("R12 rdata cleared", rdata, 32'h0);
    busRead(12'h008, 32'h0, "R12 led word cleared");
    busRead(12'h020, 32'h0, "R12 lock cleared");
    busRead(12'h040, 32'h0, "R12 rstctl cleared");
    busRead(12'h030, 32'h0, "R12 flags cleared");
    busRead(12'h028, 32'h0, "R12 cfg1 cleared");
    busRead(12'h02C, 32'h0, "R12 cfg2 cleared");
    busRead(12'h038, 32'h8000_000A, "R7 nv survives rstN");
    drain();

    porN = 1'b0;
    @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    busRead(12'h038, 32'h0, "R7 nv cleared by porN");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule